// File: doc/BRIEF.md
# Logarithmic-Pitch PWM Tone Generator

This block drives a piezo buzzer from a byte-wide register window. Software writes a 16-bit pitch code, which maps onto audio frequency exponentially: each step of 6553.5 in the code raises the pitch by one octave, giving ten octaves in total from 20 Hz at code 0 to about 20 kHz at the top code. A separate 8-bit loudness value sets the share of each period during which the output pin is high.

Internally the pitch code becomes an octave count plus a fraction. The fraction goes through a small power-of-two table with linear interpolation. The octave count then shifts the result. The outcome is a phase increment, and a phase accumulator adds it on every clock. The PWM pin is high while the phase is below a threshold scaled by the duty byte. A frequency change does not reset the phase, so new pitches take effect without a discontinuity.

Top module: `buzz_top`

## Requirements
- R1: After reset, every byte of the window reads 0 and `pwm_o` is low.
- R2: Window offsets: 0 is pitch code bits [7:0], 1 is pitch code bits [15:8], 2 is duty, 3 is a spare byte. Each offset reads back the last value written there, and `rdata_o` follows `addr_i` combinationally.
- R3: With pitch code F, the output period is CLK_HZ / (20 · 2^(10·F/65535)) clock cycles, within 0.5 % plus one cycle.
- R4: A write to either pitch byte on its own commits the combined code at once. The other byte keeps its value, and the new period applies from the next wrap of the phase.
- R5: A duty write leaves the period unchanged, and a pitch write leaves the duty share unchanged.
- R6: Duty 0 holds `pwm_o` low continuously.
- R7: For duty D, the output is high for D/510 of each period, within one cycle per period. Duty 255 gives a 50 % square wave.
- R8: Writing the spare byte (offset 3) changes neither the period, the duty share, nor the other three bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, the phase accumulator's time base |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Byte write strobe |
| addr_i | input | 2 | Window offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pwm_o | output | 1 | Buzzer drive |

## Verification
The bench builds the block with CLK_HZ set to 200 kHz and the default 32-bit phase and 16-segment table. At that rate the slowest pitch, 20 Hz, spans 10,000 cycles and the fastest spans about ten. Both ends of the ten-octave range can therefore be measured over several full periods within the run. The intermediate codes include single-byte updates and pitches in the middle of a table segment, so interpolation accuracy is checked against the exponential law computed in real arithmetic.

// File: rtl/buzz_pkg.sv
`timescale 1ns/1ps
package buzz_pkg;

  typedef enum logic [1:0] {
    SEL_PITCH_LO = 2'd0,
    SEL_PITCH_HI = 2'd1,
    SEL_DUTY     = 2'd2,
    SEL_SPARE    = 2'd3
  } win_sel_e;

  // 2^(i/n) in Q1.15, entry n equals 2.0
  function automatic logic [16:0] exp2_entry(input int i, input int n);
    real v;
    v = 32768.0 * (2.0 ** (real'(i) / real'(n)));
    return 17'($rtoi(v + 0.5));
  endfunction

endpackage

// File: rtl/buzz_regs.sv
`timescale 1ns/1ps
module buzz_regs
  import buzz_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic [15:0] pitch_o,
  output logic [7:0]  duty_o
);

  logic [7:0] pitch_lo_q, pitch_hi_q, duty_q, spare_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pitch_lo_q <= '0;
      pitch_hi_q <= '0;
      duty_q     <= '0;
      spare_q    <= '0;
    end else if (we_i) begin
      case (win_sel_e'(addr_i))
        SEL_PITCH_LO: pitch_lo_q <= wdata_i;
        SEL_PITCH_HI: pitch_hi_q <= wdata_i;
        SEL_DUTY:     duty_q     <= wdata_i;
        default:      spare_q    <= wdata_i;
      endcase
    end
  end

  always_comb begin
    case (win_sel_e'(addr_i))
      SEL_PITCH_LO: rdata_o = pitch_lo_q;
      SEL_PITCH_HI: rdata_o = pitch_hi_q;
      SEL_DUTY:     rdata_o = duty_q;
      default:      rdata_o = spare_q;
    endcase
  end

  assign pitch_o = {pitch_hi_q, pitch_lo_q};
  assign duty_o  = duty_q;

endmodule

// File: rtl/buzz_exp2.sv
`timescale 1ns/1ps
module buzz_exp2
  import buzz_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned PHASE_W  = 32,
  parameter int unsigned LUT_BITS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        code_i,
  output logic [PHASE_W-1:0] inc_o
);

  localparam int unsigned LUT_N = 1 << LUT_BITS;
  localparam int unsigned REM_W = 16 - LUT_BITS;
  localparam int unsigned KF    = 8;
  localparam int unsigned SH    = KF + 15;
  // 20 Hz increment scaled by 2^KF
  localparam logic [63:0] INC_K =
    ((64'd20 << (PHASE_W + KF)) + 64'(CLK_HZ / 2)) / 64'(CLK_HZ);

  logic [16:0] lut [LUT_N+1];
  for (genvar gi = 0; gi <= int'(LUT_N); gi++) begin : g_lut
    assign lut[gi] = exp2_entry(gi, int'(LUT_N));
  end

  logic [19:0]         scaled, expo;
  logic [3:0]          octave;
  logic [LUT_BITS:0]   idx_lo, idx_hi;
  logic [REM_W-1:0]    rem;
  logic [16:0]         diff, mant;
  logic [16+REM_W:0]   slope;
  logic [63:0]         inc_full;

  // 10*code/65535 ~= 10*code*(1 + 2^-16) / 2^16
  assign scaled = 20'(code_i) * 20'd10;
  assign expo   = scaled + {16'b0, scaled[19:16]};
  assign octave = expo[19:16];
  assign idx_lo = {1'b0, expo[15 -: LUT_BITS]};
  assign idx_hi = idx_lo + 1'b1;
  assign rem    = expo[REM_W-1:0];

  assign diff  = lut[idx_hi] - lut[idx_lo];
  assign slope = (17+REM_W)'(diff) * (17+REM_W)'(rem);
  assign mant  = lut[idx_lo] + 17'(slope >> REM_W);

  assign inc_full = (INC_K * 64'(mant)) << octave;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inc_o <= '0;
    else         inc_o <= PHASE_W'(inc_full >> SH);
  end

endmodule

// File: rtl/buzz_pwm.sv
`timescale 1ns/1ps
module buzz_pwm #(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned DUTY_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] inc_i,
  input  logic [DUTY_W-1:0]  duty_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               pwm_o
);

  localparam int unsigned CW  = PHASE_W + DUTY_W + 1;
  localparam int unsigned DEN = 2 * ((1 << DUTY_W) - 1);

  logic [PHASE_W-1:0] phase_q;
  logic [CW-1:0]      lhs, rhs;

  // phase*DEN < duty*2^PHASE_W  <=>  phase < duty/DEN of full range
  assign lhs = CW'(phase_q) * CW'(DEN);
  assign rhs = CW'(duty_i) << PHASE_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pwm_o   <= 1'b0;
    end else begin
      phase_q <= phase_q + inc_i;
      pwm_o   <= lhs < rhs;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/buzz_top.sv
`timescale 1ns/1ps
module buzz_top #(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned PHASE_W  = 32,
  parameter int unsigned LUT_BITS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       pwm_o
);

  localparam int unsigned DUTY_W = 8;

  logic [15:0]        pitch;
  logic [DUTY_W-1:0]  duty;
  logic [PHASE_W-1:0] inc;
  logic [PHASE_W-1:0] phase;

  buzz_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .pitch_o (pitch),
    .duty_o  (duty)
  );

  buzz_exp2 #(
    .CLK_HZ   (CLK_HZ),
    .PHASE_W  (PHASE_W),
    .LUT_BITS (LUT_BITS)
  ) u_exp2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (pitch),
    .inc_o  (inc)
  );

  buzz_pwm #(
    .PHASE_W (PHASE_W),
    .DUTY_W  (DUTY_W)
  ) u_pwm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (inc),
    .duty_i  (duty),
    .phase_o (phase),
    .pwm_o   (pwm_o)
  );

endmodule

// File: rtl/buzz_checker.sv
`timescale 1ns/1ps
module buzz_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [1:0]  addr_i,
  input logic [7:0]  wdata_i,
  input logic [15:0] pitch_i,
  input logic [7:0]  duty_i,
  input logic        phase_msb_i,
  input logic        pwm_i
);

  AST_PITCH_LO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0) |=> pitch_i[7:0] == $past(wdata_i)); // R2
  AST_PITCH_HI_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1) |=> pitch_i[15:8] == $past(wdata_i)); // R4
  AST_PITCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !addr_i[1]) |=> $stable(pitch_i)); // R5
  AST_DUTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 2'd2) |=> $stable(duty_i)); // R8
  AST_DUTY_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == 8'd0) |=> !pwm_i); // R6
  AST_HALF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == 8'hFF && phase_msb_i) |=> !pwm_i); // R7
  AST_HALF_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == 8'hFF && !phase_msb_i) |=> pwm_i); // R7

endmodule

bind buzz_top buzz_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .pitch_i     (pitch),
  .duty_i      (duty),
  .phase_msb_i (phase[PHASE_W-1]),
  .pwm_i       (pwm_o)
);

// File: tb/tb_buzz_top.sv
`timescale 1ns/1ps
module tb_buzz_top;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 200_000;
  localparam int WATCHDOG   = 190_000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pwm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buzz_top #(.CLK_HZ(CLK_HZ), .PHASE_W(32), .LUT_BITS(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  function automatic real exp_period(input int code);
    return real'(CLK_HZ) / (20.0 * (2.0 ** (10.0 * real'(code) / 65535.0)));
  endfunction

  function automatic real absr(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0f expected=%0f", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_pitch(input int code);
    wr(2'd0, 8'(code));
    wr(2'd1, 8'(code >> 8));
  endtask

  // period and high share over whole periods between first and last rise
  task automatic measure(input int n, output int rises, output real period,
                         output real share);
    int first = -1, last = -1, highs = 0, at_last = 0;
    logic prev = pwm;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm && !prev) begin
        if (first < 0) first = i;
        last = i;
        at_last = highs;
        rises++;
      end
      if (first >= 0 && pwm) highs++;
      prev = pwm;
    end
    if (rises >= 2) begin
      period = real'(last - first) / real'(rises - 1);
      share  = real'(at_last) / real'(last - first);
    end else begin
      period = 0.0;
      share  = 0.0;
    end
  endtask

  task automatic check_tone(input int code, input int duty, input string req,
                            input string what);
    int r; real p, s, ep, es;
    ep = exp_period(code);
    es = real'(duty) / 510.0;
    measure(int'(3.2 * ep) + 60, r, p, s);
    check(absr(p - ep) <= 0.005 * ep + 1.0, req, {what, " period"}, p, ep);
    check(absr(s - es) <= 1.0 / ep + 0.005, "R7", {what, " high share"}, s, es);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == 8'd0, "R1", $sformatf("reset read offset %0d", a), real'(d), 0.0);
    end
    begin
      int highs = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (pwm) highs++;
      end
      check(highs == 0, "R1", "pwm low after reset", real'(highs), 0.0);
    end
  endtask

  task automatic t_window();
    logic [7:0] d;
    logic [7:0] vals [4] = '{8'h3C, 8'hC3, 8'h5A, 8'hA5};
    for (int a = 0; a < 4; a++) wr(2'(a), vals[a]);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check(d == vals[a], "R2", $sformatf("readback offset %0d", a), real'(d), real'(vals[a]));
    end
  endtask

  task automatic t_pitch_law();
    int codes [5] = '{0, 6554, 20000, 32768, 65535};
    wr(2'd2, 8'd255);
    for (int k = 0; k < 5; k++) begin
      set_pitch(codes[k]);
      repeat (4) @(negedge clk);
      check_tone(codes[k], 255, "R3", $sformatf("code %0d", codes[k]));
    end
  endtask

  task automatic t_single_byte();
    set_pitch(16'h8000);
    repeat (4) @(negedge clk);
    wr(2'd0, 8'hFF);
    repeat (3) @(negedge clk);
    check_tone(16'h80FF, 255, "R4", "low byte only");
    wr(2'd1, 8'h40);
    repeat (3) @(negedge clk);
    check_tone(16'h40FF, 255, "R4", "high byte only");
  endtask

  task automatic t_independence();
    set_pitch(40000);
    wr(2'd2, 8'd64);
    repeat (3) @(negedge clk);
    check_tone(40000, 64, "R5", "after duty write");
    set_pitch(45000);
    repeat (4) @(negedge clk);
    check_tone(45000, 64, "R5", "after pitch write");
  endtask

  task automatic t_silence();
    int highs = 0;
    set_pitch(65535);
    wr(2'd2, 8'd255);
    repeat (20) @(negedge clk);
    wr(2'd2, 8'd0);
    @(negedge clk);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pwm) highs++;
    end
    check(highs == 0, "R6", "duty 0 high cycles", real'(highs), 0.0);
  endtask

  task automatic t_spare();
    logic [7:0] d;
    set_pitch(50000);
    wr(2'd2, 8'd128);
    repeat (3) @(negedge clk);
    wr(2'd3, 8'h77);
    repeat (3) @(negedge clk);
    check_tone(50000, 128, "R8", "after spare write");
    rd(2'd2, d);
    check(d == 8'd128, "R8", "duty after spare write", real'(d), 128.0);
    rd(2'd0, d);
    check(d == 8'(50000), "R8", "pitch lo after spare write", real'(d), real'(50000 % 256));
    rd(2'd1, d);
    check(d == 8'(50000 >> 8), "R8", "pitch hi after spare write", real'(d), real'(50000 / 256));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_window();
    t_pitch_law();
    t_single_byte();
    t_independence();
    t_silence();
    t_spare();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..: actual=%0d expected=%0d", WATCHDOG, 0);
      finish_run();
    end
  end

endmodule